// File: doc/BRIEF.md
# PWM Gate and Output Combiner

This block merges two compare-match levels and one external pulse train into one gate signal and two output signals. It is meant to sit between a compare stage and a pulse generator. The gate starts the pulse generator, and the pulse train then comes back and is laid over the compare levels to form the two outputs.

A 2-bit mode input picks one of three behaviours. In pass mode each output carries either its compare level or the pulse train. In compare-gated mode the compare levels drive the gate and act as windows on the pulse train. In timer-gated mode a rising edge on either compare input sets a window flag, and one shared, retriggerable down-counter decides how long the windows stay open. Both flags drop together when the counter expires, and each new rising edge reloads the counter.

Top module: `pwm_gate_combiner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `gate_o`, `out0_o` and `out1_o` are low, and both window flags are clear.
- R2: With `mode` 00 or 11 (pass), `gate_o` is low. `out0_o` equals `pulse_in` when `out_sel[0]` is 1 and `cmp0` otherwise. `out1_o` equals `pulse_in` when `out_sel[1]` is 1 and `cmp1` otherwise.
- R3: In modes 01 and 10, `gate_sel` picks the gate: 00 gives low, 01 gives source 0, 10 gives source 1, 11 gives the OR of both sources.
- R4: With `mode` 01 (compare-gated), the gate sources are `cmp0` and `cmp1`. Output k is `cmp_k AND pulse_in` when `out_sel[k]` is 1 and `cmp_k` unchanged when it is 0.
- R5: With `mode` 10 (timer-gated), flag k is set when `cmp_k` is high at a clock edge and was low at the previous edge. Flags 0 and 1 are the gate sources.
- R6: Each rising edge loads the shared counter from `reload`, which is sampled only at that load. Both flags clear together max(`reload`,1) cycles after the last rising edge.
- R7: A rising edge on either input while a flag is set reloads the counter, so a flag that is already set stays set past one timer period.
- R8: In mode 10, output k equals flag k when `out_sel[k]` is 0 and `flag_k AND pulse_in` when `out_sel[k]` is 1.
- R9: Outside mode 10 both flags are held clear. On entry to mode 10, inputs that are already high set no flag, so both outputs stay low until a fresh rising edge arrives.
- R10: Every output is registered. A change on any input becomes visible at the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00/11 pass, 01 compare-gated, 10 timer-gated |
| gate_sel | input | 2 | Gate source select |
| out_sel | input | 2 | Per-output pulse-overlay select, bit k for output k |
| reload | input | TMR_W | Window timer length in cycles |
| cmp0 | input | 1 | Compare level 0 |
| cmp1 | input | 1 | Compare level 1 |
| pulse_in | input | 1 | External pulse train |
| gate_o | output | 1 | Gate to the pulse generator |
| out0_o | output | 1 | Combined output 0 |
| out1_o | output | 1 | Combined output 1 |

## Verification
The hardest case to reach is the overlap: a rising edge on the second compare input must land while the first window is still open. The bench spaces the two edges closer together than the reload length, then counts how many cycles each output stays high, so a missing reload shows up as a short first window. Mode entry with both compare inputs already high is also checked. This makes sure a stale edge history sets no flag.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    MD_PASS  = 2'b00,
    MD_CMP   = 2'b01,
    MD_TMR   = 2'b10,
    MD_PASS2 = 2'b11
  } mode_e;

  function automatic logic gate_pick(input logic [1:0] sel, input logic [1:0] src);
    case (sel)
      2'b01:   gate_pick = src[0];
      2'b10:   gate_pick = src[1];
      2'b11:   gate_pick = src[0] | src[1];
      default: gate_pick = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pgc_flag_timer.sv
module pgc_flag_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       cmp,
  input  logic [TMR_W-1:0] reload,
  output logic [1:0]       flag_n
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [1:0]       cmp_q;
  logic [1:0]       flag_q;
  logic [1:0]       rise;
  logic [TMR_W-1:0] cnt_q, cnt_n;

  assign rise = cmp & ~cmp_q;

  always_comb begin
    flag_n = flag_q;
    cnt_n  = cnt_q;
    if (!en) begin
      flag_n = 2'b00;
      cnt_n  = '0;
    end else if (|rise) begin
      flag_n = flag_q | rise;
      cnt_n  = reload;
    end else if (|flag_q) begin
      if (cnt_q <= ONE) begin
        flag_n = 2'b00;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    cmp_q <= cmp;
    if (rst) begin
      flag_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/pgc_out_mux.sv
module pgc_out_mux
  import pgc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  mode_e          mode,
  input  logic [1:0]     gate_sel,
  input  logic [NCH-1:0] out_sel,
  input  logic [NCH-1:0] cmp,
  input  logic [NCH-1:0] flag,
  input  logic           pulse,
  output logic           gate,
  output logic [NCH-1:0] outs
);
  always_comb begin
    case (mode)
      MD_CMP:  gate = gate_pick(gate_sel, cmp[1:0]);
      MD_TMR:  gate = gate_pick(gate_sel, flag[1:0]);
      default: gate = 1'b0;
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_comb begin
      case (mode)
        MD_CMP:  outs[k] = out_sel[k] ? (cmp[k] & pulse) : cmp[k];
        MD_TMR:  outs[k] = out_sel[k] ? (flag[k] & pulse) : flag[k];
        default: outs[k] = out_sel[k] ? pulse : cmp[k];
      endcase
    end
  end
endmodule

// File: rtl/pwm_gate_combiner.sv
module pwm_gate_combiner
  import pgc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [1:0]       gate_sel,
  input  logic [1:0]       out_sel,
  input  logic [TMR_W-1:0] reload,
  input  logic             cmp0,
  input  logic             cmp1,
  input  logic             pulse_in,
  output logic             gate_o,
  output logic             out0_o,
  output logic             out1_o
);
  localparam int NCH = 2;

  mode_e          mode_e_w;
  logic [NCH-1:0] cmp_w, flag_w, outs_w;
  logic           gate_w;

  assign mode_e_w = mode_e'(mode);
  assign cmp_w    = {cmp1, cmp0};

  pgc_flag_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .en     (mode_e_w == MD_TMR),
    .cmp    (cmp_w),
    .reload (reload),
    .flag_n (flag_w)
  );

  pgc_out_mux #(.NCH(NCH)) u_mux (
    .mode     (mode_e_w),
    .gate_sel (gate_sel),
    .out_sel  (out_sel),
    .cmp      (cmp_w),
    .flag     (flag_w),
    .pulse    (pulse_in),
    .gate     (gate_w),
    .outs     (outs_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o <= 1'b0;
      out0_o <= 1'b0;
      out1_o <= 1'b0;
    end else begin
      gate_o <= gate_w;
      out0_o <= outs_w[0];
      out1_o <= outs_w[1];
    end
  end
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [1:0] gate_sel,
  input logic [1:0] out_sel,
  input logic       cmp0,
  input logic       cmp1,
  input logic       pulse_in,
  input logic       gate_o,
  input logic       out0_o,
  input logic       out1_o
);
  // R2
  pass_gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> !gate_o);

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b01 || mode == 2'b10) && gate_sel == 2'b00) |=> !gate_o);

  // R4
  cmp_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && out_sel[0] && !cmp0) |=> !out0_o);

  // R5
  tmr_edge_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && out_sel[1] == 1'b0 && $rose(cmp1)) |=> out1_o);

  // R8
  tmr_pulse_and_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && out_sel[0] && !pulse_in) |=> !out0_o);
endmodule

bind pwm_gate_combiner pgc_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .gate_sel (gate_sel),
  .out_sel  (out_sel),
  .cmp0     (cmp0),
  .cmp1     (cmp1),
  .pulse_in (pulse_in),
  .gate_o   (gate_o),
  .out0_o   (out0_o),
  .out1_o   (out1_o)
);

// File: tb/sim_pwm_gate_combiner.sv
`timescale 1ns/1ps
module sim_pwm_gate_combiner;
  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode = 2'b00;
  logic [1:0]       gate_sel = 2'b00;
  logic [1:0]       out_sel = 2'b00;
  logic [TMR_W-1:0] reload = '0;
  logic             cmp0 = 1'b0;
  logic             cmp1 = 1'b0;
  logic             pulse_in = 1'b0;
  logic             gate_o, out0_o, out1_o;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    pulse_en = 1'b0;
  bit    live = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_p0, m_p1, m_f0, m_f1;
  int m_left;
  bit e_gate, e_o0, e_o1;

  always #4 clk = ~clk;

  pwm_gate_combiner #(.TMR_W(TMR_W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .gate_sel(gate_sel), .out_sel(out_sel),
    .reload(reload), .cmp0(cmp0), .cmp1(cmp1), .pulse_in(pulse_in),
    .gate_o(gate_o), .out0_o(out0_o), .out1_o(out1_o)
  );

  function automatic bit pick(input logic [1:0] s, input bit a, input bit b);
    if (s == 2'b01) return a;
    if (s == 2'b10) return b;
    if (s == 2'b11) return a | b;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit r0, r1;
    if (rst) begin
      m_f0 = 0; m_f1 = 0; m_left = 0;
      e_gate = 0; e_o0 = 0; e_o1 = 0;
    end else begin
      r0 = cmp0 && !m_p0;
      r1 = cmp1 && !m_p1;
      if (mode == 2'b10) begin
        if (r0 || r1) begin
          if (r0) m_f0 = 1;
          if (r1) m_f1 = 1;
          m_left = (reload == 0) ? 1 : int'(reload);
        end else if (m_left > 0) begin
          m_left = m_left - 1;
          if (m_left == 0) begin m_f0 = 0; m_f1 = 0; end
        end
      end else begin
        m_f0 = 0; m_f1 = 0; m_left = 0;
      end
      if (mode == 2'b01) begin
        e_gate = pick(gate_sel, cmp0, cmp1);
        e_o0 = out_sel[0] ? (cmp0 & pulse_in) : cmp0;
        e_o1 = out_sel[1] ? (cmp1 & pulse_in) : cmp1;
      end else if (mode == 2'b10) begin
        e_gate = pick(gate_sel, m_f0, m_f1);
        e_o0 = out_sel[0] ? (m_f0 & pulse_in) : m_f0;
        e_o1 = out_sel[1] ? (m_f1 & pulse_in) : m_f1;
      end else begin
        e_gate = 0;
        e_o0 = out_sel[0] ? pulse_in : cmp0;
        e_o1 = out_sel[1] ? pulse_in : cmp1;
      end
    end
    m_p0 = cmp0;
    m_p1 = cmp1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      checks++;
      if ({gate_o, out1_o, out0_o} !== {e_gate, e_o1, e_o0}) begin
        errors++;
        $display("FAIL %s cycle %0d: gate/out1/out0 actual %b%b%b expected %b%b%b",
                 cur_req, cyc, gate_o, out1_o, out0_o, e_gate, e_o1, e_o0);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    cyc++;
    pulse_in = pulse_en ? ((cyc % 3) != 0) : 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_bit(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (out0_o) c0++;
      if (out1_o) c1++;
    end
  endtask

  initial begin
    int c0, c1;
    // R1 reset state
    cmp0 = 1; cmp1 = 1; out_sel = 2'b11; pulse_en = 1;
    ticks(3);
    expect_bit("R1", gate_o | out0_o | out1_o, 1'b0);
    rst = 0;
    tick();
    live = 1;
    cmp0 = 0; cmp1 = 0; out_sel = 2'b00;
    tick();

    // R2 pass mode, every output select and both pass encodings
    cur_req = "R2";
    for (int m = 0; m < 4; m += 3) begin
      mode = 2'(m);
      for (int s = 0; s < 4; s++) begin
        out_sel = 2'(s); gate_sel = 2'b11;
        for (int p = 0; p < 4; p++) begin
          cmp0 = p[0]; cmp1 = p[1];
          ticks(2);
        end
      end
    end

    // R10 one-cycle latency
    mode = 2'b00; out_sel = 2'b00; cmp0 = 0;
    ticks(2);
    cmp0 = 1;
    #1 expect_bit("R10", out0_o, 1'b0);
    tick();
    expect_bit("R10", out0_o, 1'b1);

    // R3 / R4 compare-gated mode
    mode = 2'b01;
    for (int g = 0; g < 4; g++) begin
      gate_sel = 2'(g);
      cur_req = "R3";
      for (int p = 0; p < 4; p++) begin
        cmp0 = p[0]; cmp1 = p[1];
        tick();
        tick();
        expect_bit("R3", gate_o, pick(2'(g), p[0], p[1]));
      end
    end
    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      out_sel = 2'(s);
      for (int p = 0; p < 4; p++) begin
        cmp0 = p[0]; cmp1 = p[1];
        ticks(4);
      end
    end

    // R9 entry with inputs already high
    cur_req = "R9";
    mode = 2'b00; cmp0 = 1; cmp1 = 1; out_sel = 2'b00; gate_sel = 2'b11; reload = 16'd5;
    ticks(2);
    mode = 2'b10;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_bit("R9", gate_o | out0_o | out1_o, 1'b0);
    end

    // R5 / R6 single window length
    cur_req = "R6";
    reload = 16'd4; cmp0 = 0; cmp1 = 0;
    ticks(2);
    cmp0 = 1;
    count_high(12, c0, c1);
    expect_int("R6", c0, 4);
    expect_int("R5", c1, 0);

    // reload value zero gives a one-cycle window
    cmp0 = 0; reload = 16'd0;
    ticks(2);
    cmp0 = 1;
    count_high(6, c0, c1);
    expect_int("R6", c0, 1);

    // R7 overlapping edges reload the shared counter
    cur_req = "R7";
    cmp0 = 0; cmp1 = 0; reload = 16'd6;
    ticks(2);
    cmp0 = 1;
    ticks(3);
    cmp1 = 1;
    count_high(16, c0, c1);
    expect_int("R7", c0 + 3, 9);
    expect_int("R7", c1, 6);

    // R8 pulse overlay and R3 gate selects on flags
    cur_req = "R8";
    pulse_en = 1;
    for (int s = 0; s < 4; s++) begin
      out_sel = 2'(s); gate_sel = 2'(3 - s); reload = 16'(3 + s);
      cmp0 = 0; cmp1 = 0;
      ticks(2);
      cmp1 = 1;
      ticks(2);
      cmp0 = 1;
      ticks(10);
    end

    // R9 leaving timer mode clears flags
    cur_req = "R9";
    out_sel = 2'b00; reload = 16'd20; cmp0 = 0;
    ticks(2);
    cmp0 = 1;
    ticks(2);
    mode = 2'b01;
    tick();
    mode = 2'b10;
    tick();
    tick();
    expect_bit("R9", out0_o, 1'b0);

    live = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule